// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer for a 10-bit successive-approximation converter. Software starts a conversion by writing the start bit. Sampling then stops. After a short alignment delay, the block runs a conversion clock taken either from a divided system clock or from an internal-oscillator tick. On each conversion-clock period it decides one result bit, starting with the most significant. It drives a trial code to an external DAC and reads an external comparator.

When the last period ends, three things happen on the same clock edge: the result register takes the new value, the start bit drops and the completion flag rises. Sampling then resumes. The result register keeps its earlier value for the whole conversion, so software may read it at any time. Clearing the start bit in software abandons a conversion with no side effects. The completion flag stays set until software clears it with a one-cycle clear strobe.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, go_o=0, flag_o=0, sampling_o=1, result_o=0 and dac_code_o=0.
- R2: clk_sel_i is captured when a conversion starts. Values 0, 1, 2 and 3 make the conversion clock the system clock divided by 2, 8, 32 and 64. Values 4 to 7 make each high cycle of osc_tick_i one conversion-clock period.
- R3: Count from the clock edge that captures go_set_i. flag_o is seen high after START_DLY + 11*DIV edges in divider modes. In oscillator mode with osc_tick_i held high, it is seen high after START_DLY + INSTR_CYC + 11 edges.
- R4: Bits are decided from bit 9 down to bit 0. During each trial, dac_code_o holds the bits already decided with the bit under test set. The bit is kept when cmp_i is 1 and cleared when it is 0. The final result equals the largest code for which the comparator reported high.
- R5: result_o keeps its previous value for the whole conversion.
- R6: At completion, on one and the same edge, result_o loads the new code, go_o falls, flag_o rises and sampling_o returns to 1.
- R7: A go_clr_i pulse while go_o=1 aborts the conversion. On the next cycle go_o=0 and sampling_o=1. result_o is unchanged and flag_o is never set for that conversion.
- R8: A flag_clr_i pulse clears flag_o on the next edge. If completion falls on the same edge as flag_clr_i, completion wins and flag_o is 1.
- R9: A go_set_i pulse while go_o=1 is ignored. The running conversion keeps its latency and its result.
- R10: sampling_o is 0 from the edge that captures go_set_i until completion or abort, and go_o is 1 over the same span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_set_i | input | 1 | Software write that sets the start bit |
| go_clr_i | input | 1 | Software write that clears the start bit (abort) |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the completion flag |
| clk_sel_i | input | 3 | Conversion-clock source select |
| osc_tick_i | input | 1 | Internal-oscillator tick |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial level |
| dac_code_o | output | 10 | Trial code driven to the DAC |
| sampling_o | output | 1 | High while the sample-and-hold tracks the input |
| go_o | output | 1 | Start bit; high while a conversion is in progress |
| result_o | output | 10 | Result register |
| flag_o | output | 1 | Completion (interrupt) flag |

## Verification
The completion of a conversion and a software flag-clear strobe can land on the same clock edge, and these two actions pull the flag in opposite directions. The bench knows exactly when completion happens, because the latency follows from the requirements. It raises flag_clr_i so that the strobe is present at that completion edge. It then expects flag_o to read 1 afterwards, with the new result loaded. A second, isolated clear strobe must then bring the flag to 0.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_DELAY = 2'd1,
      SQ_RUN   = 2'd2
   } seq_state_t;

   localparam int SEL_W = 3;
endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen #(
   parameter int DIV0 = 2,
   parameter int DIV1 = 8,
   parameter int DIV2 = 32,
   parameter int DIV3 = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         en_i,
   input  logic [sar_seq_pkg::SEL_W-1:0] sel_i,
   input  logic                         osc_tick_i,
   output logic                         tick_o
);
   localparam int CNT_W = $clog2(DIV3);

   if (DIV0 < 2 || DIV1 < 2 || DIV2 < 2 || DIV3 < 2) begin : g_bad_div
      $error("sar_tad_gen: every divisor must be at least 2");
   end
   if (DIV0 > DIV3 || DIV1 > DIV3 || DIV2 > DIV3) begin : g_bad_order
      $error("sar_tad_gen: DIV3 must be the largest divisor");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic             osc_sel;
   logic             div_hit;

   assign osc_sel = sel_i[2];

   always_comb begin
      case (sel_i[1:0])
         2'd0:    lim = CNT_W'(DIV0 - 1);
         2'd1:    lim = CNT_W'(DIV1 - 1);
         2'd2:    lim = CNT_W'(DIV2 - 1);
         default: lim = CNT_W'(DIV3 - 1);
      endcase
   end

   assign div_hit = (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en_i || osc_sel || div_hit) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = en_i && (osc_sel ? osc_tick_i : div_hit);

   // R2
   div_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && !osc_sel) |=> !tick_o);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic             cmp_i,
   output logic [RES_W-1:0] code_o
);
   if (RES_W < 2) begin : g_bad_width
      $error("sar_trial_reg: RES_W must be at least 2");
   end

   localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

   logic [RES_W-1:0] code_q;
   logic [RES_W-1:0] probe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         probe_q <= '0;
      end else if (load_i) begin
         code_q  <= TOP_BIT;
         probe_q <= TOP_BIT;
      end else if (step_i && (|probe_q)) begin
         code_q  <= (cmp_i ? code_q : (code_q & ~probe_q)) | (probe_q >> 1);
         probe_q <= probe_q >> 1;
      end
   end

   assign code_o = code_q;

   // R4
   bit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && (|probe_q) && cmp_i) |=> ((code_o & $past(probe_q)) != '0));
   // R4
   bit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && (|probe_q) && !cmp_i) |=> ((code_o & $past(probe_q)) == '0));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
   parameter int RES_W     = 10,
   parameter int START_DLY = 1,
   parameter int INSTR_CYC = 4,
   parameter int DIV0      = 2,
   parameter int DIV1      = 8,
   parameter int DIV2      = 32,
   parameter int DIV3      = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_set_i,
   input  logic             go_clr_i,
   input  logic             flag_clr_i,
   input  logic [2:0]       clk_sel_i,
   input  logic             osc_tick_i,
   input  logic             cmp_i,
   output logic [RES_W-1:0] dac_code_o,
   output logic             sampling_o,
   output logic             go_o,
   output logic [RES_W-1:0] result_o,
   output logic             flag_o
);
   import sar_seq_pkg::*;

   if (START_DLY < 1) begin : g_bad_dly
      $error("sar_conv_seq: START_DLY must be at least 1");
   end
   if (INSTR_CYC < 0) begin : g_bad_instr
      $error("sar_conv_seq: INSTR_CYC must not be negative");
   end

   localparam int DLY_W = $clog2(START_DLY + INSTR_CYC + 1);
   localparam int TAD_W = $clog2(RES_W + 1);
   localparam logic [TAD_W-1:0] TAD_LAST = TAD_W'(RES_W);
   localparam logic [DLY_W-1:0] DLY_DIV  = DLY_W'(START_DLY - 1);
   localparam logic [DLY_W-1:0] DLY_OSC  = DLY_W'(START_DLY + INSTR_CYC - 1);

   seq_state_t       state_q;
   logic [DLY_W-1:0] dly_q;
   logic [TAD_W-1:0] tad_q;
   logic [SEL_W-1:0] sel_q;
   logic [RES_W-1:0] result_q;
   logic             flag_q;
   logic             tick;
   logic             done_evt;
   logic             load_trial;
   logic             step_trial;
   logic [RES_W-1:0] trial_code;

   sar_tad_gen #(
      .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
   ) u_tad (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (state_q == SQ_RUN),
      .sel_i      (sel_q),
      .osc_tick_i (osc_tick_i),
      .tick_o     (tick)
   );

   sar_trial_reg #(.RES_W(RES_W)) u_trial (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_trial),
      .step_i (step_trial),
      .cmp_i  (cmp_i),
      .code_o (trial_code)
   );

   assign load_trial = (state_q == SQ_DELAY) && (dly_q == '0) && !go_clr_i;
   assign step_trial = (state_q == SQ_RUN) && tick && !go_clr_i;
   assign done_evt   = step_trial && (tad_q == TAD_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         dly_q    <= '0;
         tad_q    <= '0;
         sel_q    <= '0;
         result_q <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (go_set_i) begin
                  sel_q   <= clk_sel_i;
                  dly_q   <= clk_sel_i[2] ? DLY_OSC : DLY_DIV;
                  state_q <= SQ_DELAY;
               end
            end
            SQ_DELAY: begin
               if (go_clr_i) begin
                  state_q <= SQ_IDLE;
               end else if (dly_q == '0) begin
                  tad_q   <= '0;
                  state_q <= SQ_RUN;
               end else begin
                  dly_q <= dly_q - 1'b1;
               end
            end
            SQ_RUN: begin
               if (go_clr_i) begin
                  state_q <= SQ_IDLE;
               end else if (done_evt) begin
                  result_q <= trial_code;
                  state_q  <= SQ_IDLE;
               end else if (tick) begin
                  tad_q <= tad_q + 1'b1;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (done_evt) begin
         flag_q <= 1'b1;
      end else if (flag_clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign go_o       = (state_q != SQ_IDLE);
   assign sampling_o = (state_q == SQ_IDLE);
   assign result_o   = result_q;
   assign flag_o     = flag_q;
   assign dac_code_o = trial_code;

   // R5
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_o && $past(go_o)) |-> $stable(result_o));
   // R6
   done_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> (!go_o && sampling_o));
   // R7
   abort_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_o && go_clr_i) |=> (!go_o && $stable(result_o)));
   // R8
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && !done_evt) |=> !flag_o);
   // R9
   busy_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_o && go_set_i && !go_clr_i && !done_evt) |=> go_o);
endmodule

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
   localparam int RES_W     = 10;
   localparam int START_DLY = 1;
   localparam int INSTR_CYC = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             go_set_i = 1'b0;
   logic             go_clr_i = 1'b0;
   logic             flag_clr_i = 1'b0;
   logic [2:0]       clk_sel_i = 3'd0;
   logic             osc_tick_i = 1'b1;
   logic             cmp_i;
   logic [RES_W-1:0] dac_code_o;
   logic             sampling_o;
   logic             go_o;
   logic [RES_W-1:0] result_o;
   logic             flag_o;

   int vin = 0;
   int n_total = 0;
   int n_fail = 0;
   int exp_q[$];
   logic flag_prev = 1'b0;
   logic finished = 1'b0;

   always #4 clk = ~clk;

   // comparator model: high when the trial level is at or below the input
   assign cmp_i = (int'(dac_code_o) <= vin);

   sar_conv_seq #(
      .RES_W(RES_W), .START_DLY(START_DLY), .INSTR_CYC(INSTR_CYC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .go_set_i(go_set_i), .go_clr_i(go_clr_i),
      .flag_clr_i(flag_clr_i), .clk_sel_i(clk_sel_i), .osc_tick_i(osc_tick_i),
      .cmp_i(cmp_i), .dac_code_o(dac_code_o), .sampling_o(sampling_o),
      .go_o(go_o), .result_o(result_o), .flag_o(flag_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops an expected result at every rising edge of the flag
   always @(negedge clk) begin
      if (rst_n && flag_o && !flag_prev) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected flag", 1, 0);
         end else begin
            int e;
            e = exp_q.pop_front();
            check(int'(result_o) == e, "R4 result", int'(result_o), e);
         end
      end
      flag_prev = flag_o;
   end

   task automatic pulse_go();
      @(negedge clk);
      go_set_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      go_set_i = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk);
      flag_clr_i = 1'b1;
      @(negedge clk);
      flag_clr_i = 1'b0;
      check(flag_o == 1'b0, "R8 clear", int'(flag_o), 0);
   endtask

   task automatic do_conv(input int sel, input int value, input int exp_lat,
                          input bit clr_at_end, input bit busy_go);
      int n;
      logic [RES_W-1:0] old;
      vin = value;
      clk_sel_i = 3'(sel);
      old = result_o;
      exp_q.push_back(value);
      pulse_go();
      n = 0;
      while (n < 5000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (flag_o) break;
         if (n == 3) begin
            check(result_o == old, "R5 hold", int'(result_o), int'(old));
            check(!sampling_o && go_o, "R10 busy", int'(sampling_o), 0);
         end
         if (busy_go && n == 5) go_set_i = 1'b1;
         if (busy_go && n == 6) go_set_i = 1'b0;
         if (clr_at_end && n == exp_lat - 1) flag_clr_i = 1'b1;
      end
      flag_clr_i = 1'b0;
      check(n == exp_lat, "R3 latency", n, exp_lat);
      check(!go_o && sampling_o, "R6 go/sampling", int'(go_o), 0);
      if (clr_at_end) check(flag_o == 1'b1, "R8 set wins", int'(flag_o), 1);
      clear_flag();
   endtask

   initial begin
      #1;
      check(go_o == 0 && flag_o == 0, "R1 go/flag", int'(go_o) + int'(flag_o), 0);
      check(sampling_o == 1'b1, "R1 sampling", int'(sampling_o), 1);
      check(result_o == '0 && dac_code_o == '0, "R1 codes", int'(result_o), 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 / R3 / R4: each divider, several inputs
      do_conv(0, 682, START_DLY + 11 * 2, 1'b0, 1'b0);
      do_conv(1, 1023, START_DLY + 11 * 8, 1'b0, 1'b0);
      do_conv(2, 0, START_DLY + 11 * 32, 1'b0, 1'b0);
      do_conv(3, 341, START_DLY + 11 * 64, 1'b0, 1'b0);
      // R2 / R3: oscillator source adds the instruction-cycle delay
      do_conv(5, 512, START_DLY + INSTR_CYC + 11, 1'b0, 1'b0);
      do_conv(7, 1, START_DLY + INSTR_CYC + 11, 1'b0, 1'b0);
      // R9: start request while busy is ignored
      do_conv(1, 777, START_DLY + 11 * 8, 1'b0, 1'b1);
      // R8: flag clear on the completion edge
      do_conv(0, 300, START_DLY + 11 * 2, 1'b1, 1'b0);

      // R7: abort in the middle of a conversion
      begin
         logic [RES_W-1:0] old;
         old = result_o;
         vin = 100;
         clk_sel_i = 3'd1;
         pulse_go();
         repeat (20) @(negedge clk);
         go_clr_i = 1'b1;
         @(negedge clk);
         go_clr_i = 1'b0;
         check(!go_o && sampling_o, "R7 abort go", int'(go_o), 0);
         repeat (200) @(negedge clk);
         check(result_o == old, "R7 result kept", int'(result_o), int'(old));
         check(flag_o == 1'b0, "R7 no flag", int'(flag_o), 0);
      end

      // a later conversion still works after the abort
      do_conv(0, 513, START_DLY + 11 * 2, 1'b0, 1'b0);
      check(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end
endmodule